// File: doc/BRIEF.md
# SPI Peripheral Register Bridge

This block is the target side of an SPI link. It turns each 64-bit command frame from an external controller into exactly one read or one write on a simple internal register bus. The same frame carries the answer back: read data, an acknowledge bit and a 2-bit status.

A frame starts with a direction flag and a 15-bit register address. In a write frame, 32 data bits follow on MOSI. In a read frame, a gap of 8 bit times follows, and the register bus must answer within it. The read data then goes out on MISO. Every frame ends with an 8-bit trailer on MISO.

The SPI pins are sampled by a fast system clock through short synchroniser chains. The whole block therefore runs in the register-bus clock domain.

Top module: `spi_regbus_bridge`

## Requirements
- R1: Frames are shifted most significant bit first. Frame bit 0 (the first bit) is the direction flag, 1 for write and 0 for read. Frame bits 1 to 15 are the register address, address MSB first, and this address is presented on `req_addr` with the request.
- R2: In a write frame, frame bits 16 to 47 are the write data, MSB first. Once bit 47 has been sampled, `req_wr` pulses high for exactly one clock with that data on `req_wdata`, and `req_rd` stays low.
- R3: In a read frame, `req_rd` pulses high for exactly one clock once the last address bit (frame bit 15) has been sampled, and `req_wr` stays low. The two strobes are never high together.
- R4: In a read frame, the `resp_rdata` accepted with `resp_ack` is sent on MISO in frame bits 24 to 55, MSB first.
- R5: In every frame, MISO carries zeros in frame bits 56 to 60, the acknowledge flag in bit 61, `resp_status[1]` in bit 62 and `resp_status[0]` in bit 63.
- R6: A response counts only if it arrives after the request and before frame bit 24 (read) or frame bit 56 (write) is sampled. Without such a response, the frame returns ack 0, status 00 and zero read data. A late response changes nothing.
- R7: Raising chip select before the request point aborts the frame with no bus access. Raising it after the request discards the result. In both cases the bit count restarts, so the next frame is decoded from its own first bit.
- R8: MISO is low while chip select is high.
- R9: MOSI is sampled on rising SCLK edges, and MISO changes only after falling SCLK edges, so MISO is stable while SCLK is high.
- R10: After reset, both request strobes are low and MISO is low.
- R11: SCLK rising edges beyond the 64th in one chip-select period are ignored: no second request, and MISO stays low.
- R12: In a write frame, MISO is low outside the trailer; read data from the bus is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and register-bus clock; SPI pins are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock from the controller, idles low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller |
| req_wr | output | 1 | One-clock register write strobe |
| req_rd | output | 1 | One-clock register read strobe |
| req_addr | output | 15 | Register address for the current request |
| req_wdata | output | 32 | Register write data |
| resp_ack | input | 1 | Register bus answer strobe |
| resp_status | input | 2 | Status accompanying the answer |
| resp_rdata | input | 32 | Read data accompanying the answer |

## Verification
The bench times bus answers on both sides of the gap deadline. A design that closed the window too early, or never closed it, would send ack 1 on a late answer or drop a timely one. It aborts frames before and after the request point. A counter that was not cleared would misdecode the following frame, and an abort that did not stop the request would issue a spurious write. It also clocks past bit 64, checks that MISO falls back low after a trailer ending in a 1, and checks that MISO is unchanged across each high SCLK phase. A design that shifted on the wrong edge, leaked write-response data, or left MISO driven would fail these checks.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

    // Trailer layout: padding, then ack, then status
    localparam int STATUS_W     = 2;
    localparam int TRAILER_BITS = 8;

    typedef enum logic {
        CMD_RD = 1'b0,
        CMD_WR = 1'b1
    } cmd_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sel,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_bit
);

    typedef struct packed {
        logic [STAGES-1:0] sclk_ff;
        logic [STAGES-1:0] csn_ff;
        logic [STAGES-1:0] mosi_ff;
        logic              sclk_last;
    } sync_t;

    sync_t q, d;
    logic  sclk_s;

    assign sclk_s = q.sclk_ff[STAGES-1];

    always_comb begin
        d           = q;
        d.sclk_ff   = {q.sclk_ff[STAGES-2:0], sclk};
        d.csn_ff    = {q.csn_ff[STAGES-2:0], cs_n};
        d.mosi_ff   = {q.mosi_ff[STAGES-2:0], mosi};
        d.sclk_last = sclk_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sclk_ff   <= '0;
            q.csn_ff    <= '1;
            q.mosi_ff   <= '0;
            q.sclk_last <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sel       = ~q.csn_ff[STAGES-1];
    assign sclk_rise = sclk_s & ~q.sclk_last;
    assign sclk_fall = ~sclk_s & q.sclk_last;
    assign mosi_bit  = q.mosi_ff[STAGES-1];

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_bridge_pkg::*;
#(
    parameter int  ADDR_W   = 15,
    parameter int  DATA_W   = 32,
    parameter int  GAP_BITS = 8,
    localparam int FRAME_BITS = 1 + ADDR_W + DATA_W + GAP_BITS + TRAILER_BITS,
    localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  logic                sclk_rise,
    input  logic                mosi_bit,
    output logic                req_wr,
    output logic                req_rd,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [DATA_W-1:0]   req_wdata,
    input  logic                resp_ack,
    input  logic [STATUS_W-1:0] resp_status,
    input  logic [DATA_W-1:0]   resp_rdata,
    output logic [CNT_W-1:0]    bit_cnt,
    output cmd_e                dir,
    output logic                ans_ack,
    output logic [STATUS_W-1:0] ans_status,
    output logic [DATA_W-1:0]   ans_rdata
);

    localparam int RD_ISSUE = 1 + ADDR_W;
    localparam int WR_ISSUE = RD_ISSUE + DATA_W;
    localparam int RD_CLOSE = RD_ISSUE + GAP_BITS;
    localparam int WR_CLOSE = WR_ISSUE + GAP_BITS;

    typedef struct packed {
        logic [CNT_W-1:0]    cnt;
        logic [DATA_W-2:0]   shreg;
        cmd_e                dir;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic                req_wr;
        logic                req_rd;
        logic                pending;
        logic                ack;
        logic [STATUS_W-1:0] status;
        logic [DATA_W-1:0]   rdata;
    } eng_t;

    eng_t              q, d;
    logic [DATA_W-1:0] shift_nx;
    logic [CNT_W-1:0]  cnt_nx;
    logic [CNT_W-1:0]  close_pt;

    assign close_pt = (q.dir == CMD_WR) ? CNT_W'(WR_CLOSE) : CNT_W'(RD_CLOSE);

    always_comb begin
        d        = q;
        d.req_wr = 1'b0;
        d.req_rd = 1'b0;
        shift_nx = {q.shreg, mosi_bit};
        cnt_nx   = q.cnt + 1'b1;

        // first answer inside the window is taken
        if (q.pending && resp_ack) begin
            d.pending = 1'b0;
            d.ack     = 1'b1;
            d.status  = resp_status;
            d.rdata   = (q.dir == CMD_WR) ? '0 : resp_rdata;
        end

        if (!sel) begin
            d.cnt     = '0;
            d.pending = 1'b0;
        end else if (sclk_rise && (q.cnt != CNT_W'(FRAME_BITS))) begin
            d.shreg = shift_nx[DATA_W-2:0];
            d.cnt   = cnt_nx;
            if (cnt_nx == CNT_W'(RD_ISSUE)) begin
                d.dir  = cmd_e'(shift_nx[ADDR_W]);
                d.addr = shift_nx[ADDR_W-1:0];
                if (shift_nx[ADDR_W] == 1'b0) begin
                    d.req_rd  = 1'b1;
                    d.pending = 1'b1;
                    d.ack     = 1'b0;
                    d.status  = '0;
                    d.rdata   = '0;
                end
            end
            if ((cnt_nx == CNT_W'(WR_ISSUE)) && (q.dir == CMD_WR)) begin
                d.wdata   = shift_nx;
                d.req_wr  = 1'b1;
                d.pending = 1'b1;
                d.ack     = 1'b0;
                d.status  = '0;
                d.rdata   = '0;
            end
            if (cnt_nx == close_pt) begin
                d.pending = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_wr     = q.req_wr;
    assign req_rd     = q.req_rd;
    assign req_addr   = q.addr;
    assign req_wdata  = q.wdata;
    assign bit_cnt    = q.cnt;
    assign dir        = q.dir;
    assign ans_ack    = q.ack;
    assign ans_status = q.status;
    assign ans_rdata  = q.rdata;

    // R2: write strobe lasts one clock
    a_r2_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.req_wr |=> !q.req_wr);

    // R3: read strobe lasts one clock
    a_r3_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.req_rd |=> !q.req_rd);

    // R6: an answer is never awaited past the closing bit
    a_r6_window_closed: assert property (@(posedge clk) disable iff (!rst_n)
        q.pending |-> (q.cnt < close_pt));

    // R7: chip select release restarts the frame and drops any wait
    a_r7_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> ((q.cnt == '0) && !q.pending));

    // R11: bit count never passes the frame length
    a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(FRAME_BITS));

endmodule

// File: rtl/spi_miso_drive.sv
module spi_miso_drive
    import spi_bridge_pkg::*;
#(
    parameter int  ADDR_W   = 15,
    parameter int  DATA_W   = 32,
    parameter int  GAP_BITS = 8,
    localparam int FRAME_BITS = 1 + ADDR_W + DATA_W + GAP_BITS + TRAILER_BITS,
    localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  logic                sclk_fall,
    input  logic [CNT_W-1:0]    bit_cnt,
    input  cmd_e                dir,
    input  logic                ans_ack,
    input  logic [STATUS_W-1:0] ans_status,
    input  logic [DATA_W-1:0]   ans_rdata,
    output logic                miso
);

    localparam int RD_FIRST  = 1 + ADDR_W + GAP_BITS;
    localparam int RD_LAST   = RD_FIRST + DATA_W - 1;
    localparam int TR_FIRST  = FRAME_BITS - TRAILER_BITS;
    localparam int ACK_POS   = FRAME_BITS - STATUS_W - 1;
    localparam int IDX_W     = $clog2(DATA_W);
    localparam int TIDX_W    = $clog2(TRAILER_BITS);

    typedef struct packed {
        logic miso;
    } drv_t;

    drv_t                    q, d;
    logic [TRAILER_BITS-1:0] trailer;
    logic [IDX_W-1:0]        data_idx;
    logic [TIDX_W-1:0]       tr_idx;
    logic                    nxt_bit;
    int                      pos;

    assign trailer = {{(TRAILER_BITS - 1 - STATUS_W){1'b0}}, ans_ack, ans_status};

    always_comb begin
        pos      = int'(bit_cnt);
        data_idx = IDX_W'(RD_LAST - pos);
        tr_idx   = TIDX_W'(FRAME_BITS - 1 - pos);
        nxt_bit  = 1'b0;
        if ((dir == CMD_RD) && (pos >= RD_FIRST) && (pos <= RD_LAST)) begin
            nxt_bit = ans_rdata[data_idx];
        end else if ((pos >= TR_FIRST) && (pos < FRAME_BITS)) begin
            nxt_bit = trailer[tr_idx];
        end
    end

    always_comb begin
        d = q;
        if (!sel) begin
            d.miso = 1'b0;
        end else if (sclk_fall) begin
            d.miso = nxt_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign miso = q.miso;

    // R9: output moves only after a falling edge or on deselect
    a_r9_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.miso) |-> ($past(sclk_fall) || !$past(sel)));

    // R5: padding bits go out low
    a_r5_pad_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && sclk_fall && (pos >= TR_FIRST) && (pos < ACK_POS)) |=> !q.miso);

endmodule

// File: rtl/spi_regbus_bridge.sv
module spi_regbus_bridge
    import spi_bridge_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int DATA_W      = 32,
    parameter int GAP_BITS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk,
    input  logic                cs_n,
    input  logic                mosi,
    output logic                miso,
    output logic                req_wr,
    output logic                req_rd,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [DATA_W-1:0]   req_wdata,
    input  logic                resp_ack,
    input  logic [STATUS_W-1:0] resp_status,
    input  logic [DATA_W-1:0]   resp_rdata
);

    localparam int FRAME_BITS = 1 + ADDR_W + DATA_W + GAP_BITS + TRAILER_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    logic                sel, sclk_rise, sclk_fall, mosi_bit;
    logic [CNT_W-1:0]    bit_cnt;
    cmd_e                dir;
    logic                ans_ack;
    logic [STATUS_W-1:0] ans_status;
    logic [DATA_W-1:0]   ans_rdata;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .sel       (sel),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_bit  (mosi_bit)
    );

    spi_cmd_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAP_BITS(GAP_BITS)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .sclk_rise   (sclk_rise),
        .mosi_bit    (mosi_bit),
        .req_wr      (req_wr),
        .req_rd      (req_rd),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .resp_ack    (resp_ack),
        .resp_status (resp_status),
        .resp_rdata  (resp_rdata),
        .bit_cnt     (bit_cnt),
        .dir         (dir),
        .ans_ack     (ans_ack),
        .ans_status  (ans_status),
        .ans_rdata   (ans_rdata)
    );

    spi_miso_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAP_BITS(GAP_BITS)) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .sclk_fall  (sclk_fall),
        .bit_cnt    (bit_cnt),
        .dir        (dir),
        .ans_ack    (ans_ack),
        .ans_status (ans_status),
        .ans_rdata  (ans_rdata),
        .miso       (miso)
    );

    // R3: never a read and a write in the same clock
    a_r3_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_wr && req_rd));

    // R8: deselected for a clock means MISO is low
    a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && $past(!sel)) |-> !miso);

endmodule

// File: tb/tb_spi_regbus_bridge.sv
module tb_spi_regbus_bridge;

    localparam int HALF = 8;   // SPI half period in system clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic        req_wr, req_rd;
    logic [14:0] req_addr;
    logic [31:0] req_wdata;
    logic        resp_ack = 1'b0;
    logic [1:0]  resp_status = 2'b00;
    logic [31:0] resp_rdata = 32'h0;

    always #2 clk = ~clk;   // 250 MHz

    spi_regbus_bridge dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk        (sclk),
        .cs_n        (cs_n),
        .mosi        (mosi),
        .miso        (miso),
        .req_wr      (req_wr),
        .req_rd      (req_rd),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .resp_ack    (resp_ack),
        .resp_status (resp_status),
        .resp_rdata  (resp_rdata)
    );

    int          n_checks = 0;
    int          n_fail   = 0;
    int          n_wr = 0, n_rd = 0;
    logic [14:0] seen_addr = '0;
    logic [31:0] seen_wdata = '0;
    int          bus_lat = 3;
    logic [1:0]  bus_sts = 2'b00;
    logic [14:0] bus_a;
    logic        bus_w;

    function automatic logic [31:0] rd_pattern(input logic [14:0] a);
        return {a, 2'b10, ~a};
    endfunction

    task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // request monitor
    initial forever begin
        @(negedge clk);
        if (req_wr) begin n_wr++; seen_addr = req_addr; seen_wdata = req_wdata; end
        if (req_rd) begin n_rd++; seen_addr = req_addr; end
    end

    // register bus model
    initial forever begin
        @(negedge clk);
        if (req_wr || req_rd) begin
            bus_a = req_addr;
            bus_w = req_wr;
            repeat (bus_lat - 1) @(negedge clk);
            resp_ack    = 1'b1;
            resp_status = bus_sts;
            resp_rdata  = bus_w ? 32'hBAD0_BAD0 : rd_pattern(bus_a);
            @(negedge clk);
            resp_ack    = 1'b0;
            resp_status = 2'b00;
            resp_rdata  = 32'h0;
        end
    end

    task automatic spi_xfer(input logic [79:0] tx, input int nbits,
                            output logic [79:0] rx, output logic [79:0] rx_hi);
        rx = '0;
        rx_hi = '0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = tx[79-i];
            repeat (HALF) @(negedge clk);
            rx[79-i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            rx_hi[79-i] = miso;
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (4 * HALF) @(negedge clk);
    endtask

    typedef struct packed {
        logic        wr;
        logic [14:0] addr;
        logic [31:0] data;
        logic [1:0]  sts;
        logic [7:0]  lat;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 15'h7ABC, 32'hDEADBEEF, 2'd0, 8'd3},
        '{1'b0, 15'h7ABC, 32'h0,        2'd0, 8'd3},
        '{1'b0, 15'h0001, 32'h0,        2'd2, 8'd90},
        '{1'b1, 15'h4000, 32'h00000001, 2'd3, 8'd40},
        '{1'b0, 15'h7FFF, 32'h0,        2'd1, 8'd200},
        '{1'b1, 15'h0000, 32'hFFFFFFFF, 2'd2, 8'd200}
    };

    logic [79:0] rx, rxh;
    logic [63:0] frame, expf;
    int          wr0, rd0;

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 strobes", 80'({req_wr, req_rd}), 80'(0));
        check("R10 miso", 80'(miso), 80'(0));

        // R8: bus activity with chip select high
        wr0 = n_wr; rd0 = n_rd;
        mosi = 1'b1;
        for (int i = 0; i < 10; i++) begin
            sclk = 1'b1; repeat (HALF) @(negedge clk);
            sclk = 1'b0; repeat (HALF) @(negedge clk);
            check("R8 idle miso", 80'(miso), 80'(0));
        end
        mosi = 1'b0;
        check("R8 idle no request", 80'((n_wr - wr0) + (n_rd - rd0)), 80'(0));

        // vector table
        for (int v = 0; v < NV; v++) begin
            bus_lat = int'(VECS[v].lat);
            bus_sts = VECS[v].sts;
            wr0 = n_wr; rd0 = n_rd;
            frame = VECS[v].wr ? {1'b1, VECS[v].addr, VECS[v].data, 16'h0}
                               : {1'b0, VECS[v].addr, 48'h0};
            spi_xfer({frame, 16'h0}, 64, rx, rxh);
            expf = '0;
            if (VECS[v].lat < 8'd100) begin
                expf[2]   = 1'b1;
                expf[1:0] = VECS[v].sts;
                if (!VECS[v].wr) expf[39:8] = rd_pattern(VECS[v].addr);
            end
            if (VECS[v].wr) begin
                check("R2 one write", 80'({n_wr - wr0, n_rd - rd0}), 80'({32'd1, 32'd0}));
                check("R2 write data", 80'(seen_wdata), 80'(VECS[v].data));
                check("R12 write miso frame", 80'(rx[79:16]), 80'(expf));
            end else begin
                check("R3 one read", 80'({n_wr - wr0, n_rd - rd0}), 80'({32'd0, 32'd1}));
                check("R4 read miso frame", 80'(rx[79:16]), 80'(expf));
            end
            check("R1 address", 80'(seen_addr), 80'(VECS[v].addr));
            check(VECS[v].lat < 8'd100 ? "R5 trailer" : "R6 timeout trailer",
                  80'(rx[18:16]), 80'(expf[2:0]));
            check("R9 miso stable while sclk high", rxh, rx);
            check("R8 miso low after frame", 80'(miso), 80'(0));
        end

        // R7: abort a write before its request point
        bus_lat = 3; bus_sts = 2'd1;
        wr0 = n_wr; rd0 = n_rd;
        spi_xfer({1'b1, 15'h1234, 32'hCAFEF00D, 32'h0}, 30, rx, rxh);
        check("R7 aborted write no access", 80'((n_wr - wr0) + (n_rd - rd0)), 80'(0));
        // R7: abort a read after its request; then a clean read
        spi_xfer({1'b0, 15'h2222, 64'h0}, 20, rx, rxh);
        check("R7 aborted read issued once", 80'(n_rd - rd0), 80'(1));
        bus_sts = 2'd3;
        rd0 = n_rd;
        spi_xfer({1'b0, 15'h0155, 64'h0}, 64, rx, rxh);
        expf = '0;
        expf[39:8] = rd_pattern(15'h0155);
        expf[2:0] = 3'b111;
        check("R7 frame after abort", 80'(rx[79:16]), 80'(expf));
        check("R7 address after abort", 80'(seen_addr), 80'(15'h0155));

        // R11: extra clocks past bit 64
        bus_sts = 2'd1;
        wr0 = n_wr; rd0 = n_rd;
        spi_xfer({1'b1, 15'h0AAA, 32'h13572468, 16'h0, 16'hFFFF}, 70, rx, rxh);
        check("R11 single write", 80'({n_wr - wr0, n_rd - rd0}), 80'({32'd1, 32'd0}));
        check("R11 miso past frame", 80'(rx[15:0]), 80'(0));
        check("R11 write data", 80'(seen_wdata), 80'(32'h13572468));
        check("R5 trailer with extra clocks", 80'(rx[23:16]), 80'(8'b0000_0101));

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule